// File: doc/BRIEF.md
# Multi-Channel Return-to-Zero Burst Pattern Generator

This block drives the logic-level control pairs of an eight-channel return-to-zero high-voltage pulser from a 40 MHz reference clock. Each channel gets a positive-drive line and a negative-drive line. One half-cycle of a burst raises exactly one of the two lines. Between bursts both lines sit low, which returns the pulser output to zero. The pair with both lines high means high impedance in the pulser, so the generator never produces it.

A free-running counter raises an internal trigger once every 4096 reference clocks. On each trigger the generator may start a burst. It first checks the output enable and the selected waveform. It then latches the waveform, frequency and polarity settings, which come from a separate control block. It raises a one-clock sync strobe and plays one or three full bipolar cycles on all channels at once. The half-cycle length comes from a power-of-two division of the reference clock. Settings that change during a burst wait for the next burst.

The sequencer is a three-state machine:
- ST_IDLE: both lines low on every channel.
- ST_POS: positive line high.
- ST_NEG: negative line high.

Its transitions are:
- ST_IDLE to ST_POS, on a start whose first half is positive.
- ST_IDLE to ST_NEG, on a start whose first half is negative.
- ST_POS to ST_NEG, and ST_NEG to ST_POS, when a half-cycle ends and more halves remain.
- ST_POS or ST_NEG back to ST_IDLE, when the last half ends or the output enable drops.

Top module: `rtz_burst_gen`

## Requirements
- R1: While `rst_n` is low, every `pos_drv` and `neg_drv` bit and `sync` are 0.
- R2: A burst can start only on the internal trigger, which fires every 4096 clocks. The first trigger comes on the 4096th rising edge after reset is released. `sync` is high for exactly one clock, in the same cycle as the first half-cycle of the burst.
- R3: `freq_sel` codes 0, 1, 2, 3 and 4 give half-cycles of 2, 4, 8, 16 and 32 clocks. These are full periods of 4, 8, 16, 32 and 64 clocks. Codes 5 to 7 act as code 4.
- R4: `wave_sel` code 1 gives one cycle, code 2 gives one inverted cycle, code 3 gives three cycles, and code 4 gives three inverted cycles. One cycle is two half-cycles.
- R5: A burst starts with a positive half unless exactly one of these holds: the waveform is an inverted one, or `phase_inv` is 1. In that case it starts with a negative half. Halves alternate after the first.
- R6: In a positive half, `pos_drv`=1 and `neg_drv`=0. In a negative half, `pos_drv`=0 and `neg_drv`=1. When idle, both are 0. The pair 1/1 never appears on any channel.
- R7: All channels carry the same code in every cycle.
- R8: `wave_sel`, `freq_sel` and `phase_inv` are sampled only when a burst starts. Changing them during a burst does not alter that burst.
- R9: While `out_en` is 0, all outputs are 0 in the same cycle. A running burst is abandoned and does not resume. No burst starts on a trigger seen while `out_en` is 0.
- R10: `wave_sel` code 0, and codes 5 to 7, select no burst: no `sync` pulse and no drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| out_en | input | 1 | Output enable; low forces idle |
| wave_sel | input | 3 | Waveform choice (0 none, 1..4 bursts) |
| freq_sel | input | 3 | Division choice (0..4 give divide by 4..64) |
| phase_inv | input | 1 | Swaps the order of the half-cycles |
| pos_drv | output | NUM_CH | Positive-drive line per channel |
| neg_drv | output | NUM_CH | Negative-drive line per channel |
| sync | output | 1 | One-clock strobe at burst start |

## Verification
The hardest case to reach from the ports is a burst that is already running when something changes. One such change is a setting update, which must be ignored until the next burst. The other is an enable drop, which must silence the outputs at once and stay silent after the enable returns. The stimulus waits for `sync`, counts a fixed number of cycles into the burst, and makes the change at a falling edge. It keeps checking the remainder of that burst against the pattern latched at its start. It then checks the following trigger period against the new settings.

// File: rtl/rtz_pkg.sv
package rtz_pkg;

    localparam int WAVE_W    = 3;
    localparam int FREQ_W    = 3;
    localparam int HALF_W    = 6;
    localparam int CYC_W     = 2;
    localparam int HALVES_W  = CYC_W + 1;
    localparam int FREQ_MAX  = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_POS  = 2'd1,
        ST_NEG  = 2'd2
    } burst_state_t;

    // Full cycles per burst for a waveform code; 0 means no burst.
    function automatic logic [CYC_W-1:0] wave_cycles(input logic [WAVE_W-1:0] w);
        logic [CYC_W-1:0] r;
        unique case (w)
            3'd1, 3'd2: r = 2'd1;
            3'd3, 3'd4: r = 2'd3;
            default:    r = 2'd0;
        endcase
        return r;
    endfunction

    function automatic logic wave_inverted(input logic [WAVE_W-1:0] w);
        return (w == 3'd2) || (w == 3'd4);
    endfunction

    // Half-cycle length minus one, in reference clocks.
    function automatic logic [HALF_W-1:0] half_len_m1(input logic [FREQ_W-1:0] f);
        logic [FREQ_W-1:0] fc;
        fc = (f > FREQ_W'(FREQ_MAX)) ? FREQ_W'(FREQ_MAX) : f;
        return (HALF_W'(2) << fc) - HALF_W'(1);
    endfunction

endpackage

// File: rtl/rtz_trigger.sv
module rtz_trigger #(
    parameter int PERIOD = 4096
) (
    input  logic clk,
    input  logic rst_n,
    output logic trig
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign trig = (cnt_q == LAST);

    AST_TRIG_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (cnt_q == '0 && !trig)); // R2

endmodule

// File: rtl/rtz_half_timer.sv
module rtz_half_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/rtz_burst_fsm.sv
module rtz_burst_fsm
    import rtz_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              out_en,
    input  logic [WAVE_W-1:0] wave_sel,
    input  logic [FREQ_W-1:0] freq_sel,
    input  logic              phase_inv,
    output logic              drive_pos,
    output logic              drive_neg,
    output logic              sync
);
    burst_state_t          state_q, state_d;
    logic [HALF_W-1:0]     half_m1_q;
    logic [HALVES_W-1:0]   halves_left_q;
    logic                  sync_q;
    logic                  half_done;
    logic                  start;
    logic                  busy;
    logic                  last_half;
    logic                  advance;
    logic                  first_neg;
    logic [CYC_W-1:0]      cycles_sel;
    logic                  tmr_load;
    logic [HALF_W-1:0]     tmr_val;

    assign cycles_sel = wave_cycles(wave_sel);
    assign first_neg  = wave_inverted(wave_sel) ^ phase_inv;
    assign busy       = (state_q != ST_IDLE);
    assign last_half  = (halves_left_q == '0);
    assign start      = !busy && trig && out_en && (cycles_sel != '0);
    assign advance    = busy && out_en && half_done && !last_half;
    assign tmr_load   = start || advance;
    assign tmr_val    = start ? half_len_m1(freq_sel) : half_m1_q;

    rtz_half_timer #(.W(HALF_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (half_done)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = first_neg ? ST_NEG : ST_POS;
                end
            end
            ST_POS: begin
                if (!out_en) begin
                    state_d = ST_IDLE;
                end else if (half_done) begin
                    state_d = last_half ? ST_IDLE : ST_NEG;
                end
            end
            ST_NEG: begin
                if (!out_en) begin
                    state_d = ST_IDLE;
                end else if (half_done) begin
                    state_d = last_half ? ST_IDLE : ST_POS;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Burst settings latched at the start, and the remaining-halves count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_m1_q     <= '0;
            halves_left_q <= '0;
            sync_q        <= 1'b0;
        end else begin
            sync_q <= start;
            if (start) begin
                half_m1_q     <= half_len_m1(freq_sel);
                halves_left_q <= {cycles_sel, 1'b0} - HALVES_W'(1);
            end else if (advance) begin
                halves_left_q <= halves_left_q - 1'b1;
            end
        end
    end

    // Output decode
    always_comb begin
        drive_pos = 1'b0;
        drive_neg = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_POS:  drive_pos = 1'b1;
            ST_NEG:  drive_neg = 1'b1;
            default: ;
        endcase
    end

    assign sync = sync_q;

    AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_q |=> !sync_q); // R2
    AST_SYNC_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        sync_q |-> ($past(trig) && state_q != ST_IDLE)); // R2
    AST_SETTINGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(half_m1_q)); // R8
    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        sync_q |-> $past(out_en)); // R9
    AST_DROP_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !out_en) |=> (state_q == ST_IDLE)); // R9
    AST_NONE_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        sync_q |-> ($past(wave_sel) >= 3'd1 && $past(wave_sel) <= 3'd4)); // R10

endmodule

// File: rtl/rtz_burst_gen.sv
module rtz_burst_gen
    import rtz_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int TRIG_PERIOD = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              out_en,
    input  logic [WAVE_W-1:0] wave_sel,
    input  logic [FREQ_W-1:0] freq_sel,
    input  logic              phase_inv,
    output logic [NUM_CH-1:0] pos_drv,
    output logic [NUM_CH-1:0] neg_drv,
    output logic              sync
);
    logic trig;
    logic core_pos;
    logic core_neg;

    rtz_trigger #(.PERIOD(TRIG_PERIOD)) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (trig)
    );

    rtz_burst_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .out_en    (out_en),
        .wave_sel  (wave_sel),
        .freq_sel  (freq_sel),
        .phase_inv (phase_inv),
        .drive_pos (core_pos),
        .drive_neg (core_neg),
        .sync      (sync)
    );

    // Per-channel fan-out with enable gating
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign pos_drv[c] = core_pos && out_en;
        assign neg_drv[c] = core_neg && out_en;
    end

    AST_NO_HIZ_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_drv & neg_drv) == '0); // R6
    AST_CHANNELS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_drv == '0 || pos_drv == '1) && (neg_drv == '0 || neg_drv == '1)); // R7
    AST_GATED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (pos_drv == '0 && neg_drv == '0)); // R9

endmodule

// File: tb/sim_rtz_burst_gen.sv
module sim_rtz_burst_gen;

    localparam int NCH    = 8;
    localparam int PERIOD = 4096;
    localparam int NVEC   = 11;

    // Vector: [16] en, [15] phase, [14:12] wave, [11:9] freq,
    //         [8:7] expected cycles, [6:1] expected half length, [0] expected negative first
    localparam logic [16:0] VEC [0:NVEC-1] = '{
        {1'b1, 1'b0, 3'd1, 3'd0, 2'd1, 6'd2,  1'b0},
        {1'b1, 1'b0, 3'd2, 3'd1, 2'd1, 6'd4,  1'b1},
        {1'b1, 1'b1, 3'd3, 3'd2, 2'd3, 6'd8,  1'b1},
        {1'b1, 1'b1, 3'd4, 3'd3, 2'd3, 6'd16, 1'b0},
        {1'b1, 1'b0, 3'd3, 3'd4, 2'd3, 6'd32, 1'b0},
        {1'b1, 1'b0, 3'd4, 3'd6, 2'd3, 6'd32, 1'b1},
        {1'b1, 1'b1, 3'd1, 3'd4, 2'd1, 6'd32, 1'b1},
        {1'b1, 1'b0, 3'd0, 3'd0, 2'd0, 6'd0,  1'b0},
        {1'b1, 1'b0, 3'd6, 3'd0, 2'd0, 6'd0,  1'b0},
        {1'b0, 1'b0, 3'd3, 3'd0, 2'd0, 6'd0,  1'b0},
        {1'b1, 1'b1, 3'd2, 3'd7, 2'd1, 6'd32, 1'b0}
    };

    logic           clk = 1'b0;
    logic           rst_n;
    logic           out_en;
    logic [2:0]     wave_sel;
    logic [2:0]     freq_sel;
    logic           phase_inv;
    logic [NCH-1:0] pos_drv;
    logic [NCH-1:0] neg_drv;
    logic           sync;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int last_sync_cyc;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rtz_burst_gen #(.NUM_CH(NCH), .TRIG_PERIOD(PERIOD)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .out_en    (out_en),
        .wave_sel  (wave_sel),
        .freq_sel  (freq_sel),
        .phase_inv (phase_inv),
        .pos_drv   (pos_drv),
        .neg_drv   (neg_drv),
        .sync      (sync)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_sync(output bit found);
        found = 1'b0;
        for (int k = 0; k < PERIOD + 200; k++) begin
            @(negedge clk);
            if (sync === 1'b1) begin
                found = 1'b1;
                last_sync_cyc = cyc;
                break;
            end
        end
    endtask

    // Called at the falling edge where sync is seen
    task automatic check_burst(input int n, input int h, input bit fneg, input bit mutate);
        bit bad = 1'b0;
        int act_v = 0, exp_v = 0;
        for (int i = 0; i < 2 * n * h; i++) begin
            bit neg_half;
            logic [NCH-1:0] ep, en;
            neg_half = fneg ^ ((i / h) % 2 == 1);
            ep = neg_half ? '0 : '1;
            en = neg_half ? '1 : '0;
            if (!bad && (pos_drv !== ep || neg_drv !== en || (i > 0 && sync !== 1'b0))) begin
                bad = 1'b1;
                act_v = {sync, pos_drv, neg_drv};
                exp_v = {(i == 0), ep, en};
            end
            if (mutate && i == 3) begin
                wave_sel  = 3'd0;
                freq_sel  = 3'd0;
                phase_inv = ~phase_inv;
            end
            @(negedge clk);
        end
        chk(!bad, "R3 R4 R5 R6 R7 R8", "burst pattern", act_v, exp_v);
        chk(pos_drv == '0 && neg_drv == '0, "R6", "idle after burst",
            {pos_drv, neg_drv}, 0);
    endtask

    task automatic quiet_window(input int len, input string req);
        bit bad = 1'b0;
        int act_v = 0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            if (!bad && (sync !== 1'b0 || pos_drv !== '0 || neg_drv !== '0)) begin
                bad = 1'b1;
                act_v = {sync, pos_drv, neg_drv};
            end
        end
        chk(!bad, req, "no burst in window", act_v, 0);
    endtask

    task automatic apply(input logic [16:0] v);
        out_en    = v[16];
        phase_inv = v[15];
        wave_sel  = v[14:12];
        freq_sel  = v[11:9];
    endtask

    initial begin
        bit found;
        int rel_cyc;
        int prev;
        rst_n = 1'b0;
        apply(VEC[0]);
        repeat (3) @(negedge clk);
        chk(pos_drv == '0 && neg_drv == '0 && sync == 1'b0, "R1", "outputs in reset",
            {sync, pos_drv, neg_drv}, 0);
        rst_n = 1'b1;
        rel_cyc = cyc;

        // R2: first trigger position, then trigger spacing
        wait_sync(found);
        chk(found && (last_sync_cyc - rel_cyc) == PERIOD, "R2", "first sync delay",
            last_sync_cyc - rel_cyc, PERIOD);
        check_burst(1, 2, 1'b0, 1'b0);
        prev = last_sync_cyc;
        wait_sync(found);
        chk(found && (last_sync_cyc - prev) == PERIOD, "R2", "sync spacing",
            last_sync_cyc - prev, PERIOD);
        check_burst(1, 2, 1'b0, 1'b0);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            apply(VEC[v]);
            if (VEC[v][8:7] == 2'd0) begin
                quiet_window(PERIOD + 150, VEC[v][16] ? "R10" : "R9");
            end else begin
                wait_sync(found);
                chk(found, "R2", "sync seen", found, 1);
                if (found) check_burst(int'(VEC[v][8:7]), int'(VEC[v][6:1]), VEC[v][0], 1'b0);
            end
        end

        // R8: settings changed mid-burst apply only to the next trigger
        apply({1'b1, 1'b0, 3'd3, 3'd4, 2'd3, 6'd32, 1'b0});
        wait_sync(found);
        chk(found, "R8", "sync seen", found, 1);
        check_burst(3, 32, 1'b0, 1'b1);
        quiet_window(PERIOD + 150, "R8");

        // R9: enable drop mid-burst, then re-enable before the burst would end
        apply({1'b1, 1'b0, 3'd3, 3'd4, 2'd3, 6'd32, 1'b0});
        wait_sync(found);
        chk(found, "R9", "sync seen", found, 1);
        repeat (10) @(negedge clk);
        chk(pos_drv == '1 && neg_drv == '0, "R9", "driving before drop",
            {pos_drv, neg_drv}, {8'hFF, 8'h00});
        out_en = 1'b0;
        #1;
        chk(pos_drv == '0 && neg_drv == '0, "R9", "immediate idle on drop",
            {pos_drv, neg_drv}, 0);
        repeat (20) @(negedge clk);
        out_en = 1'b1;
        quiet_window(200, "R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule